// File: doc/BRIEF.md
# Two-Wire Slave Control Register

This block is a two-wire serial (I2C) slave holding one 8-bit control/status word for a supply and signalling controller. A host addresses it, writes a single byte to set six control bits, or reads the word back. The two least significant bits of the word are not storage: they show two status flags that other logic supplies live (over-temperature and overload). The six control bits leave the block as separate decoded outputs. These outputs drive the output enable, the voltage selection, the cable-drop compensation, the tone forcing, the transmit-path routing and the choice of current-limit mode.

SCL and SDA come in asynchronously. Each passes through a synchroniser and a run-length glitch filter clocked by a system clock at least 16 times the SCL rate. Bus conditions and clock edges are then decoded from the filtered lines. The slave address is `00010` followed by a 2-bit strap input. An undervoltage-lockout input silences the slave and keeps the register cleared while it is high. The slave only ever pulls SDA low, through an open-drain enable.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset all six control outputs are 0 and the SDA pull-down enable is 0.
- R2: The slave acknowledges an address byte only when its upper seven bits equal binary 00010 followed by the two strap bits (strap bit 1 first). Bit 0 of the address byte selects read (1) or write (0). A non-matching address gets no acknowledge and changes nothing.
- R3: In a write, the data byte (MSB first) is acknowledged. Its bits 7..2 load the control outputs in this mapping: bit 7 pulse-limit mode, bit 6 transmit route, bit 5 tone force, bit 4 line compensation, bit 3 high voltage, bit 2 power enable. Bits 1..0 of the written byte have no effect.
- R4: A read byte carries the control bits in bits 7..2 exactly as last written. Bit 1 is the over-temperature flag and bit 0 is the overload flag, both taken at the moment the byte starts.
- R5: A master acknowledge after a read byte makes the slave send another byte with freshly taken flags. A master not-acknowledge makes the slave release SDA and send nothing more. The slave changes its SDA drive only while SCL is low.
- R6: While the lockout input is high, the slave acknowledges no byte, the control outputs are held at 0, and writes are lost.
- R7: A START arriving in the middle of a byte abandons that byte without changing the register, and the slave goes straight to matching the next address.
- R8: A STOP arriving in the middle of a byte abandons it without changing the register.
- R9: A write accepts one data byte only: a second data byte in the same transfer is not acknowledged and does not change the register.
- R10: A pulse on SCL or SDA lasting fewer than FILT_LEN system clocks after synchronisation is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_strap_i | input | 2 | Low two address bits |
| uvlo_i | input | 1 | Undervoltage lockout active |
| otemp_flag_i | input | 1 | Over-temperature status flag (read bit 1) |
| ovld_flag_i | input | 1 | Overload status flag (read bit 0) |
| pulse_limit_o | output | 1 | Control bit 7: pulsed current-limit mode |
| tx_route_o | output | 1 | Control bit 6: transmit output path on |
| tone_force_o | output | 1 | Control bit 5: continuous tone forced |
| line_comp_o | output | 1 | Control bit 4: cable-drop compensation |
| volt_hi_o | output | 1 | Control bit 3: high output voltage |
| pwr_en_o | output | 1 | Control bit 2: power stages enabled |
| sda_pull_o | output | 1 | Open-drain SDA pull-down enable |

## Verification
The bench first writes bytes whose low two bits are set, so that a read-back shows the storage and the live flags separately. It then reads with the flags changed between bytes of a multi-byte read, which separates a snapshot at byte start from a stale copy. Address bytes are tried with matching and non-matching values under two strap settings. Transfers are also cut off by a repeated START or a STOP part-way through a byte, sent with a second data byte, sent with lockout raised, and disturbed by a two-clock SCL glitch. In each case a correct slave leaves a different register value or acknowledge pattern than a slave that commits early, decodes the address wrongly or counts the glitch as a bit.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int CTL_W   = 6;
   localparam int STAT_W  = 2;
   localparam int REG_W   = CTL_W + STAT_W;
   localparam int ADDR_W  = 7;
   localparam int STRAP_W = 2;
   localparam int BCNT_W  = $clog2(REG_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_IGNORE
   } xfer_state_t;
endpackage

// File: rtl/ctlreg_line_filter.sv
module ctlreg_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   generate
      if (FILT_LEN == 1) begin : g_direct
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= synced;
         end
         assign line_o = q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= 1'b1;
               cnt_q <= '0;
            end else if (synced == q) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
               q     <= synced;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign line_o = q;

         // R10: a new filtered level needs at least two agreeing synchronised samples
         a_r10_two_sample_run : assert property (@(posedge clk) disable iff (!rst_n)
            (line_o != $past(line_o)) |-> ($past(synced, 2) == line_o))
            else $error("filter adopted a level seen for one cycle");
      end
   endgenerate

   // R10: filtered level only follows the synchronised input
   a_r10_follows_sync : assert property (@(posedge clk) disable iff (!rst_n)
      (line_o != $past(line_o)) |-> ($past(synced) == line_o))
      else $error("filter changed without synchronised input");
endmodule

// File: rtl/ctlreg_bus_events.sv
module ctlreg_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/ctlreg_xfer_engine.sv
module ctlreg_xfer_engine
   import ctlreg_pkg::*;
#(
   parameter logic [ADDR_W-STRAP_W-1:0] DEV_ADDR_HI = 5'b00010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_f,
   input  logic               sda_f,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               uvlo_i,
   input  logic [STAT_W-1:0]  status_i,
   output logic [CTL_W-1:0]   ctl_o,
   output logic               pull_o
);
   xfer_state_t        state_q;
   logic [REG_W-1:0]   shreg_q;
   logic [REG_W-1:0]   tx_q;
   logic [BCNT_W-1:0]  bitcnt_q;
   logic [CTL_W-1:0]   ctl_q;
   logic               pull_q;
   logic               rw_q;
   logic               mack_q;
   logic               addr_hit;
   logic               byte_full;
   logic [REG_W-1:0]   rd_word;

   assign addr_hit  = (shreg_q[REG_W-1:1] == {DEV_ADDR_HI, strap_i});
   assign byte_full = (bitcnt_q == BCNT_W'(REG_W));
   assign rd_word   = {ctl_q, status_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shreg_q  <= '0;
         tx_q     <= '0;
         bitcnt_q <= '0;
         ctl_q    <= '0;
         pull_q   <= 1'b0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
      end else begin
         if (start_det) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else if (stop_det) begin
            state_q  <= ST_IDLE;
            pull_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_WR_DATA: begin
                  if (scl_rise && !byte_full) begin
                     shreg_q  <= {shreg_q[REG_W-2:0], sda_f};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall && byte_full) begin
                     bitcnt_q <= '0;
                     if (uvlo_i) begin
                        state_q <= ST_IGNORE;
                     end else if (state_q == ST_ADDR) begin
                        if (addr_hit) begin
                           state_q <= ST_ADDR_ACK;
                           pull_q  <= 1'b1;
                           rw_q    <= shreg_q[0];
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end else begin
                        ctl_q   <= shreg_q[REG_W-1 -: CTL_W];
                        pull_q  <= 1'b1;
                        state_q <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt_q <= '0;
                     if (rw_q) begin
                        state_q <= ST_RD_DATA;
                        tx_q    <= rd_word;
                        pull_q  <= ~rd_word[REG_W-1];
                     end else begin
                        state_q <= ST_WR_DATA;
                        pull_q  <= 1'b0;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     pull_q  <= 1'b0;
                     state_q <= ST_IGNORE;
                  end
               end
               ST_RD_DATA: begin
                  if (scl_fall) begin
                     if (bitcnt_q == BCNT_W'(REG_W - 1)) begin
                        pull_q   <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= ST_RD_ACK;
                     end else begin
                        tx_q     <= {tx_q[REG_W-2:0], 1'b0};
                        pull_q   <= ~tx_q[REG_W-2];
                        bitcnt_q <= bitcnt_q + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) mack_q <= ~sda_f;
                  if (scl_fall) begin
                     if (mack_q) begin
                        state_q  <= ST_RD_DATA;
                        tx_q     <= rd_word;
                        pull_q   <= ~rd_word[REG_W-1];
                        bitcnt_q <= '0;
                     end else begin
                        state_q  <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end

         if (uvlo_i) begin
            ctl_q  <= '0;
            pull_q <= 1'b0;
            if (!start_det && !stop_det && state_q != ST_IDLE && state_q != ST_ADDR)
               state_q <= ST_IGNORE;
         end
      end
   end

   assign ctl_o  = ctl_q;
   assign pull_o = pull_q;

   // R6: lockout clears the register and silences the drive on the next cycle
   a_r6_lockout_clear : assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |=> (ctl_q == '0 && !pull_q))
      else $error("register or drive active under lockout");

   // R3: control bits change only at the end of a write data byte
   a_r3_commit_point : assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_q != $past(ctl_q)) && !$past(uvlo_i)) |-> ($past(state_q) == ST_WR_DATA))
      else $error("control bits changed outside a write");

   // R7: START always restarts address matching with SDA released
   a_r7_start_restarts : assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state_q == ST_ADDR && !pull_q))
      else $error("START did not restart the slave");

   // R8: STOP always returns to idle
   a_r8_stop_idles : assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state_q == ST_IDLE))
      else $error("STOP did not idle the slave");

   // R5: the pull-down only starts while SCL is low
   a_r5_drive_scl_low : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> !scl_f)
      else $error("SDA drive started with SCL high");

   // R2: an idle slave never pulls SDA
   a_r2_idle_released : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !pull_q)
      else $error("SDA pulled while idle");
endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
   import ctlreg_pkg::*;
#(
   parameter int                        SYNC_STAGES = 2,
   parameter int                        FILT_LEN    = 3,
   parameter logic [ADDR_W-STRAP_W-1:0] DEV_ADDR_HI = 5'b00010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] addr_strap_i,
   input  logic               uvlo_i,
   input  logic               otemp_flag_i,
   input  logic               ovld_flag_i,
   output logic               pulse_limit_o,
   output logic               tx_route_o,
   output logic               tone_force_o,
   output logic               line_comp_o,
   output logic               volt_hi_o,
   output logic               pwr_en_o,
   output logic               sda_pull_o
);
   localparam int N_LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] clean_lines;
   logic               scl_rise, scl_fall, start_det, stop_det;
   logic [CTL_W-1:0]   ctl;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      ctlreg_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[g]),
         .line_o (clean_lines[g])
      );
   end

   ctlreg_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (clean_lines[0]),
      .sda_f     (clean_lines[1]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ctlreg_xfer_engine #(
      .DEV_ADDR_HI (DEV_ADDR_HI)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (clean_lines[0]),
      .sda_f     (clean_lines[1]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap_i   (addr_strap_i),
      .uvlo_i    (uvlo_i),
      .status_i  ({otemp_flag_i, ovld_flag_i}),
      .ctl_o     (ctl),
      .pull_o    (sda_pull_o)
   );

   assign {pulse_limit_o, tx_route_o, tone_force_o, line_comp_o, volt_hi_o, pwr_en_o} = ctl;
endmodule

// File: tb/ctlreg_i2c_slave_tb.sv
module ctlreg_i2c_slave_tb;
   localparam int HALF   = 8;
   localparam int WDOG   = 150000;

   typedef struct {
      string tag;
      int    val;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b01;
   logic       uvlo = 1'b0;
   logic       otemp = 1'b0;
   logic       ovld = 1'b0;
   logic       pl, tr, tf, lc, vh, pe, sda_pull;
   logic       sda_line;

   item_t exp_q[$];
   int    obs_q[$];
   int    n_checks = 0;
   int    n_fail = 0;
   int    cyc = 0;

   assign sda_line = sda_m & ~sda_pull;

   always #2.5 clk = ~clk;

   ctlreg_i2c_slave u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl),
      .sda_i         (sda_line),
      .addr_strap_i  (strap),
      .uvlo_i        (uvlo),
      .otemp_flag_i  (otemp),
      .ovld_flag_i   (ovld),
      .pulse_limit_o (pl),
      .tx_route_o    (tr),
      .tone_force_o  (tf),
      .line_comp_o   (lc),
      .volt_hi_o     (vh),
      .pwr_en_o      (pe),
      .sda_pull_o    (sda_pull)
   );

   // monitor: pops expected items as observations arrive
   always @(negedge clk) begin
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
         item_t e;
         int    o;
         e = exp_q.pop_front();
         o = obs_q.pop_front();
         n_checks++;
         if (o != e.val) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, o, e.val);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_val(input string tag, input int val, input int obs);
      item_t it;
      it.tag = tag;
      it.val = val;
      exp_q.push_back(it);
      obs_q.push_back(obs);
   endtask

   function automatic int ctl_vec();
      return int'({pl, tr, tf, lc, vh, pe});
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; tick(HALF);
      scl = 1'b1;   tick(HALF);
      sda_m = 1'b0; tick(2*HALF);
      scl = 1'b0;   tick(HALF);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(HALF);
      scl = 1'b1;   tick(HALF);
      sda_m = 1'b1; tick(4*HALF);
   endtask

   task automatic send_range(input logic [7:0] v, input int msb, input int lsb);
      for (int i = msb; i >= lsb; i--) begin
         sda_m = v[i]; tick(HALF);
         scl = 1'b1;   tick(2*HALF);
         scl = 1'b0;   tick(HALF);
      end
   endtask

   task automatic ack_slot(output logic ack);
      sda_m = 1'b1; tick(HALF);
      scl = 1'b1;   tick(HALF);
      ack = ~sda_line;
      tick(HALF);
      scl = 1'b0;   tick(HALF);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send_range(v, 7, 0);
      ack_slot(ack);
   endtask

   task automatic recv_byte(input logic give_ack, input logic upd, input logic [1:0] nf,
                            output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; tick(HALF);
         scl = 1'b1;   tick(HALF);
         d[i] = sda_line;
         tick(HALF);
         scl = 1'b0;   tick(HALF);
      end
      if (upd) {otemp, ovld} = nf;
      sda_m = ~give_ack; tick(HALF);
      scl = 1'b1;        tick(2*HALF);
      scl = 1'b0;        tick(HALF);
      sda_m = 1'b1;
   endtask

   initial begin
      logic       ack;
      logic [7:0] d;

      tick(5);
      rst_n = 1'b1;
      tick(10);
      // R1: reset state
      expect_val("R1 control outputs after reset", 0, ctl_vec());
      expect_val("R1 sda released after reset", 0, int'(sda_pull));

      // R2/R3: write 0xA7 to address 0001001 (strap 01)
      bus_start();
      send_byte(8'h12, ack);
      expect_val("R2 matching address acknowledged", 1, int'(ack));
      send_byte(8'hA7, ack);
      expect_val("R3 data byte acknowledged", 1, int'(ack));
      bus_stop();
      expect_val("R3 control bits from bits 7..2", 6'b101001, ctl_vec());

      // R4: read back with flags otemp=1 ovld=0
      otemp = 1'b1; ovld = 1'b0;
      bus_start();
      send_byte(8'h13, ack);
      expect_val("R4 read address acknowledged", 1, int'(ack));
      recv_byte(1'b0, 1'b0, 2'b00, d);
      expect_val("R4 read word with status flags", 8'hA6, int'(d));
      tick(2*HALF);
      expect_val("R5 SDA released after master NACK", 0, int'(sda_pull));
      bus_stop();

      // R5: two-byte read, flags change between bytes
      bus_start();
      send_byte(8'h13, ack);
      recv_byte(1'b1, 1'b1, 2'b01, d);
      expect_val("R5 first byte of burst read", 8'hA6, int'(d));
      recv_byte(1'b0, 1'b0, 2'b00, d);
      expect_val("R5 second byte takes fresh flags", 8'hA5, int'(d));
      bus_stop();

      // R2: non-matching address 0001000 with strap 01
      bus_start();
      send_byte(8'h10, ack);
      expect_val("R2 foreign address not acknowledged", 0, int'(ack));
      send_byte(8'h00, ack);
      bus_stop();
      expect_val("R2 foreign write leaves register", 6'b101001, ctl_vec());

      // R6: lockout
      uvlo = 1'b1;
      tick(4);
      expect_val("R6 lockout clears control outputs", 0, ctl_vec());
      bus_start();
      send_byte(8'h12, ack);
      expect_val("R6 no acknowledge under lockout", 0, int'(ack));
      send_byte(8'hFC, ack);
      bus_stop();
      expect_val("R6 write lost under lockout", 0, ctl_vec());
      uvlo = 1'b0;
      tick(4);
      bus_start();
      send_byte(8'h13, ack);
      recv_byte(1'b0, 1'b0, 2'b00, d);
      expect_val("R6 register reads zero after lockout", 8'h01, int'(d));
      bus_stop();

      // R2/R3: strap 11 -> address 0001011
      strap = 2'b11;
      bus_start();
      send_byte(8'h16, ack);
      expect_val("R2 address follows strap", 1, int'(ack));
      send_byte(8'h5C, ack);
      bus_stop();
      expect_val("R3 second pattern written", 6'b010111, ctl_vec());

      // R9: second data byte refused
      bus_start();
      send_byte(8'h16, ack);
      send_byte(8'hFC, ack);
      expect_val("R9 first data byte acknowledged", 1, int'(ack));
      send_byte(8'h00, ack);
      expect_val("R9 second data byte not acknowledged", 0, int'(ack));
      bus_stop();
      expect_val("R9 second data byte not applied", 6'b111111, ctl_vec());

      // R7: repeated START in the middle of a data byte
      bus_start();
      send_byte(8'h16, ack);
      send_range(8'h00, 7, 4);
      bus_start();
      send_byte(8'h17, ack);
      expect_val("R7 address after restart acknowledged", 1, int'(ack));
      recv_byte(1'b0, 1'b0, 2'b00, d);
      expect_val("R7 aborted byte left register", 8'hFD, int'(d));
      bus_stop();

      // R8: STOP in the middle of a data byte
      bus_start();
      send_byte(8'h16, ack);
      send_range(8'h00, 7, 5);
      bus_stop();
      expect_val("R8 aborted byte left register", 6'b111111, ctl_vec());

      // R10: short SCL glitch during the address byte
      bus_start();
      send_range(8'h16, 7, 5);
      scl = 1'b1; tick(2);
      scl = 1'b0; tick(HALF);
      send_range(8'h16, 4, 0);
      ack_slot(ack);
      expect_val("R10 glitch ignored, address acknowledged", 1, int'(ack));
      send_byte(8'h04, ack);
      bus_stop();
      expect_val("R10 write after glitch correct", 6'b000001, ctl_vec());

      tick(20);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule